// File: doc/BRIEF.md
# Dual-View Register File with Stack Pointer

This block is the operand storage of a small 8-bit processor. It keeps eight byte registers, where register 0 serves as the accumulator. The same storage is also reachable as four 16-bit register pairs. Pair n combines byte register 2n+1, the high byte, with byte register 2n, the low byte. A separate 16-bit stack pointer sits beside them. Decode, memory and the ALU are outside the block. The decoder drives two byte read ports, one byte write port and a single pair port. On the pair port it selects one of eight pair operations.

The pair operations are: load an immediate, increment or decrement with a zero report, copy into or out of the stack pointer, and push or pop. For push and pop the block presents the stack address to the memory side in the same cycle. A push takes the pair read data as the word to store. A pop takes the word loaded from memory on the pair write-data input.

Top module: `dual_view_regfile`

## Requirements
- R1: After reset, every byte register, every pair and the stack pointer read zero.
- R2: A byte write to register i becomes visible on both byte read ports from the next cycle, and the reads are combinational.
- R3: The pair read of pair n always equals {byte register 2n+1, byte register 2n}.
- R4: Pair op 1 (load) writes pair_wdata into the selected pair at the clock edge.
- R5: Pair op 2 (increment) writes the pair plus one, wrapping 0xFFFF to 0x0000. zero_out is high in that cycle exactly when the result is 0x0000.
- R6: Pair op 3 (decrement) writes the pair minus one, wrapping 0x0000 to 0xFFFF. zero_out is high in that cycle exactly when the result is 0x0000.
- R7: zero_out is low whenever the pair op is neither 2 nor 3.
- R8: Pair op 4 loads the stack pointer from the selected pair. Pair op 5 copies the stack pointer into the selected pair.
- R9: Pair op 6 (push) shows stack_addr equal to the stack pointer minus 2 in that cycle, then leaves the stack pointer at that value. The pair is unchanged.
- R10: Pair op 7 (pop) shows stack_addr equal to the current stack pointer, writes pair_wdata into the selected pair, and adds 2 to the stack pointer.
- R11: When a byte write and a pair write hit the same pair in one cycle, both bytes of that pair take the pair value. A byte write to a different pair still takes effect.
- R12: With pair op 0 and no byte write, no register and not the stack pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_a_idx | input | 3 | Byte read port A register select |
| rd_a_data | output | 8 | Byte read port A data |
| rd_b_idx | input | 3 | Byte read port B register select |
| rd_b_data | output | 8 | Byte read port B data |
| byte_we | input | 1 | Byte write enable |
| byte_widx | input | 3 | Byte write register select |
| byte_wdata | input | 8 | Byte write data |
| pair_op | input | 3 | Pair operation: 0 none, 1 load, 2 inc, 3 dec, 4 sp from pair, 5 pair from sp, 6 push, 7 pop |
| pr_idx | input | 2 | Pair select for read and for the pair operation |
| pair_wdata | input | 16 | Immediate for load, popped word for pop |
| pr_rdata | output | 16 | Selected pair value, also the word to store on push |
| sp_out | output | 16 | Current stack pointer |
| stack_addr | output | 16 | Stack address for the memory side |
| zero_out | output | 1 | Zero result of a 16-bit increment or decrement |

## Verification
The hardest case to reach is a collision, where a byte write and a pair write hit the same pair in one cycle. The bench drives both in the same cycle on purpose. It then repeats the pair load while the byte write goes to another pair, which shows that the priority works per pair and not globally. The zero report on wrap-around is reached by loading 0xFFFF and 0x0001 before an increment or a decrement.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_LOAD   = 3'd1,
    OP_INC    = 3'd2,
    OP_DEC    = 3'd3,
    OP_SP_LD  = 3'd4,
    OP_SP_ST  = 3'd5,
    OP_PUSH   = 3'd6,
    OP_POP    = 3'd7
  } rf_op_e;
endpackage

// File: rtl/rf_byte_bank.sv
module rf_byte_bank #(
  parameter int DW   = 8,
  parameter int NREG = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NREG)-1:0]  rd_a_idx,
  output logic [DW-1:0]            rd_a_data,
  input  logic [$clog2(NREG)-1:0]  rd_b_idx,
  output logic [DW-1:0]            rd_b_data,
  input  logic                     byte_we,
  input  logic [$clog2(NREG)-1:0]  byte_widx,
  input  logic [DW-1:0]            byte_wdata,
  input  logic                     pair_we,
  input  logic [$clog2(NREG/2)-1:0] pair_idx,
  input  logic [2*DW-1:0]          pair_wdata,
  output logic [2*DW-1:0]          pair_rdata
);
  localparam int NPAIR = NREG / 2;
  localparam int RIW   = $clog2(NREG);
  localparam int PIW   = $clog2(NPAIR);

  logic [DW-1:0]   regs_w  [NREG];
  logic [2*DW-1:0] pairs_w [NPAIR];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int PSEL = g / 2;
    localparam bit HIGH = (g % 2) == 1;
    logic [DW-1:0] q, d;
    logic          en;

    always_comb begin
      d  = q;
      en = 1'b0;
      if (pair_we && pair_idx == PIW'(PSEL)) begin
        d  = HIGH ? pair_wdata[2*DW-1:DW] : pair_wdata[DW-1:0];
        en = 1'b1;
      end else if (byte_we && byte_widx == RIW'(g)) begin
        d  = byte_wdata;
        en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign regs_w[g] = q;
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pairs_w[p] = {regs_w[2*p+1], regs_w[2*p]};
  end

  assign rd_a_data  = regs_w[rd_a_idx];
  assign rd_b_data  = regs_w[rd_b_idx];
  assign pair_rdata = pairs_w[pair_idx];
endmodule

// File: rtl/rf_pair_alu.sv
module rf_pair_alu
  import regfile_pkg::*;
#(
  parameter int PW = 16
) (
  input  rf_op_e          op,
  input  logic [PW-1:0]   pair_in,
  input  logic [PW-1:0]   sp_in,
  input  logic [PW-1:0]   ext_in,
  output logic            pair_we,
  output logic [PW-1:0]   pair_res,
  output logic            zero
);
  localparam logic [PW-1:0] ONE = PW'(1);

  always_comb begin
    pair_we  = 1'b1;
    pair_res = pair_in;
    unique case (op)
      OP_LOAD:  pair_res = ext_in;
      OP_INC:   pair_res = pair_in + ONE;
      OP_DEC:   pair_res = pair_in - ONE;
      OP_SP_ST: pair_res = sp_in;
      OP_POP:   pair_res = ext_in;
      default:  pair_we  = 1'b0;
    endcase
    zero = (op == OP_INC || op == OP_DEC) && (pair_res == '0);
  end
endmodule

// File: rtl/rf_sp_unit.sv
module rf_sp_unit
  import regfile_pkg::*;
#(
  parameter int AW   = 16,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rf_op_e        op,
  input  logic [AW-1:0] pair_in,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] stack_addr
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] sp_d;
  logic          sp_en;

  always_comb begin
    sp_en = 1'b1;
    sp_d  = sp_q;
    unique case (op)
      OP_SP_LD: sp_d  = pair_in;
      OP_PUSH:  sp_d  = sp_q - STEP_V;
      OP_POP:   sp_d  = sp_q + STEP_V;
      default:  sp_en = 1'b0;
    endcase
    stack_addr = (op == OP_PUSH) ? sp_d : sp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end
endmodule

// File: rtl/dual_view_regfile.sv
module dual_view_regfile
  import regfile_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NREG)-1:0]    rd_a_idx,
  output logic [DW-1:0]              rd_a_data,
  input  logic [$clog2(NREG)-1:0]    rd_b_idx,
  output logic [DW-1:0]              rd_b_data,
  input  logic                       byte_we,
  input  logic [$clog2(NREG)-1:0]    byte_widx,
  input  logic [DW-1:0]              byte_wdata,
  input  logic [2:0]                 pair_op,
  input  logic [$clog2(NREG/2)-1:0]  pr_idx,
  input  logic [2*DW-1:0]            pair_wdata,
  output logic [2*DW-1:0]            pr_rdata,
  output logic [2*DW-1:0]            sp_out,
  output logic [2*DW-1:0]            stack_addr,
  output logic                       zero_out
);
  localparam int PW   = 2 * DW;
  localparam int STEP = PW / 8;

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  rf_op_e        op;
  logic          pair_we;
  logic [PW-1:0] pair_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign op = rf_op_e'(pair_op);

  rf_byte_bank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_idx   (rd_b_idx),
    .rd_b_data  (rd_b_data),
    .byte_we    (byte_we),
    .byte_widx  (byte_widx),
    .byte_wdata (byte_wdata),
    .pair_we    (pair_we),
    .pair_idx   (pr_idx),
    .pair_wdata (pair_res),
    .pair_rdata (pr_rdata)
  );

  rf_pair_alu #(.PW(PW)) u_alu (
    .op       (op),
    .pair_in  (pr_rdata),
    .sp_in    (sp_out),
    .ext_in   (pair_wdata),
    .pair_we  (pair_we),
    .pair_res (pair_res),
    .zero     (zero_out)
  );

  rf_sp_unit #(.AW(PW), .STEP(STEP)) u_sp (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .op         (op),
    .pair_in    (pr_rdata),
    .sp_q       (sp_out),
    .stack_addr (stack_addr)
  );
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int PW = 16,
  parameter int PIW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     pair_op,
  input logic [PIW-1:0] pr_idx,
  input logic [PW-1:0]  pair_wdata,
  input logic [PW-1:0]  pr_rdata,
  input logic [PW-1:0]  sp_out,
  input logic [PW-1:0]  stack_addr,
  input logic           zero_out
);
  localparam logic [PW-1:0] TWO = PW'(2);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_op == 3'd1) |=> (pr_idx != $past(pr_idx)) || (pr_rdata == $past(pair_wdata)));

  assert_inc_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_op == 3'd2 && pr_rdata == '1) |-> zero_out);

  assert_dec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_op == 3'd3 && pr_rdata == '0) |-> !zero_out);

  assert_zero_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_op != 3'd2 && pair_op != 3'd3) |-> !zero_out);

  assert_push_sp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_op == 3'd6) |=> sp_out == $past(sp_out) - TWO);

  assert_pop_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_op == 3'd7) |-> stack_addr == sp_out);

  assert_pop_sp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_op == 3'd7) |=> sp_out == $past(sp_out) + TWO);

  assert_sp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_op != 3'd4 && pair_op != 3'd6 && pair_op != 3'd7) |=> $stable(sp_out));
endmodule

bind dual_view_regfile rf_checker #(.PW(2*DW), .PIW($clog2(NREG/2))) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .pair_op    (pair_op),
  .pr_idx     (pr_idx),
  .pair_wdata (pair_wdata),
  .pr_rdata   (pr_rdata),
  .sp_out     (sp_out),
  .stack_addr (stack_addr),
  .zero_out   (zero_out)
);

// File: tb/tb_dual_view_regfile.sv
module tb_dual_view_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rd_a_idx, rd_b_idx, byte_widx;
  logic [7:0]  rd_a_data, rd_b_data, byte_wdata;
  logic        byte_we;
  logic [2:0]  pair_op;
  logic [1:0]  pr_idx;
  logic [15:0] pair_wdata, pr_rdata, sp_out, stack_addr;
  logic        zero_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dual_view_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .byte_we(byte_we), .byte_widx(byte_widx), .byte_wdata(byte_wdata),
    .pair_op(pair_op), .pr_idx(pr_idx), .pair_wdata(pair_wdata),
    .pr_rdata(pr_rdata), .sp_out(sp_out), .stack_addr(stack_addr),
    .zero_out(zero_out)
  );

  // op, idx, wdata, zero(pre-edge), stack_addr(pre-edge), pair(post), sp(post)
  localparam int NV = 12;
  localparam logic [69:0] VEC [NV] = '{
    {3'd1, 2'd1, 16'h1234, 1'b0, 16'h0000, 16'h1234, 16'h0000}, // R4
    {3'd2, 2'd1, 16'h0000, 1'b0, 16'h0000, 16'h1235, 16'h0000}, // R5
    {3'd4, 2'd1, 16'h0000, 1'b0, 16'h0000, 16'h1235, 16'h1235}, // R8
    {3'd6, 2'd1, 16'h0000, 1'b0, 16'h1233, 16'h1235, 16'h1233}, // R9
    {3'd7, 2'd2, 16'hBEEF, 1'b0, 16'h1233, 16'hBEEF, 16'h1235}, // R10
    {3'd1, 2'd3, 16'hFFFF, 1'b0, 16'h1235, 16'hFFFF, 16'h1235}, // R4
    {3'd2, 2'd3, 16'h0000, 1'b1, 16'h1235, 16'h0000, 16'h1235}, // R5
    {3'd3, 2'd3, 16'h0000, 1'b0, 16'h1235, 16'hFFFF, 16'h1235}, // R6
    {3'd1, 2'd0, 16'h0001, 1'b0, 16'h1235, 16'h0001, 16'h1235}, // R4
    {3'd3, 2'd0, 16'h0000, 1'b1, 16'h1235, 16'h0000, 16'h1235}, // R6
    {3'd5, 2'd0, 16'h0000, 1'b0, 16'h1235, 16'h1235, 16'h1235}, // R8
    {3'd0, 2'd2, 16'h0000, 1'b0, 16'h1235, 16'hBEEF, 16'h1235}  // R12, R7
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    pair_op = 3'd0; byte_we = 1'b0; pair_wdata = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all_zero(input string tag);
    for (int i = 0; i < 8; i++) begin
      rd_a_idx = 3'(i); #1;
      chk(tag, {8'h00, rd_a_data}, 16'h0000);
    end
    chk(tag, sp_out, 16'h0000);
  endtask

  initial begin
    idle();
    rd_a_idx = '0; rd_b_idx = '0; byte_widx = '0; byte_wdata = '0; pr_idx = '0;
    do_reset();
    check_all_zero("R1 reset");

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      pair_op    = VEC[v][69:67];
      pr_idx     = VEC[v][66:65];
      pair_wdata = VEC[v][64:49];
      #1;
      if (pair_op == 3'd2 || pair_op == 3'd3) chk("R5/R6 zero", {15'b0, zero_out}, {15'b0, VEC[v][48]});
      else                                    chk("R7 zero idle", {15'b0, zero_out}, {15'b0, VEC[v][48]});
      chk("R9/R10 stack_addr", stack_addr, VEC[v][47:32]);
      @(posedge clk); #1;
      idle();
      #0.5;
      chk("R4/R5/R6/R8/R10 pair", pr_rdata, VEC[v][31:16]);
      chk("R8/R9/R10 sp", sp_out, VEC[v][15:0]);
    end

    // R3: byte view of a pair loaded earlier (pair 2 = BEEF)
    @(negedge clk);
    rd_a_idx = 3'd5; rd_b_idx = 3'd4; #1;
    chk("R3 high byte", {8'h00, rd_a_data}, 16'h00BE);
    chk("R3 low byte",  {8'h00, rd_b_data}, 16'h00EF);

    // R2: byte writes, visible on both read ports next cycle
    @(negedge clk);
    byte_we = 1'b1; byte_widx = 3'd5; byte_wdata = 8'hA5;
    @(negedge clk);
    byte_widx = 3'd4; byte_wdata = 8'h3C;
    @(negedge clk);
    byte_we = 1'b0; rd_a_idx = 3'd4; rd_b_idx = 3'd5; pr_idx = 2'd2; #1;
    chk("R2 port A", {8'h00, rd_a_data}, 16'h003C);
    chk("R2 port B", {8'h00, rd_b_data}, 16'h00A5);
    chk("R3 pair from bytes", pr_rdata, 16'hA53C);

    // R11: collision on the same pair, pair write wins
    @(negedge clk);
    pair_op = 3'd1; pr_idx = 2'd3; pair_wdata = 16'hCAFE;
    byte_we = 1'b1; byte_widx = 3'd6; byte_wdata = 8'h77;
    @(negedge clk);
    idle(); #1;
    chk("R11 same pair", pr_rdata, 16'hCAFE);
    // R11: byte write to another pair still lands
    pair_op = 3'd1; pr_idx = 2'd3; pair_wdata = 16'h1111;
    byte_we = 1'b1; byte_widx = 3'd0; byte_wdata = 8'h55;
    @(negedge clk);
    idle(); rd_a_idx = 3'd0; #1;
    chk("R11 pair write", pr_rdata, 16'h1111);
    chk("R11 other byte", {8'h00, rd_a_data}, 16'h0055);

    // R12: idle cycles leave state unchanged
    repeat (3) @(negedge clk);
    #1;
    chk("R12 hold pair", pr_rdata, 16'h1111);
    chk("R12 hold byte", {8'h00, rd_a_data}, 16'h0055);
    chk("R12 hold sp", sp_out, 16'h1235);

    // R1: reset in mid-run clears everything again
    do_reset();
    check_all_zero("R1 re-reset");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule